// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a target on a two-wire serial bus. It gives an external bus controller access to a bank of byte-wide registers on the chip. The controller picks a register with a 16-bit subaddress that it sends as two bytes, high byte first. After each data byte the subaddress steps up by one, so a single transaction can read or write a run of consecutive registers. The block samples the clock and data lines with a faster system clock. It drives the data line only through an open-drain enable, so it can pull the line low or release it.

The upper five bits of the 7-bit device address are a parameter. The lower two bits come from strap inputs. A write transaction is the device address with R/W=0, then the two subaddress bytes, then the data bytes. A read transaction first sends the device address and both subaddress bytes as a write. The controller then issues a repeated START, sends the device address with R/W=1, and clocks out data bytes.

A subaddress outside the implemented window is refused. A write that runs past the top of the window is refused. A read that runs past the top keeps returning the top register.

Top module: `i2c_regbank_target`

## Requirements
- R1: The block acknowledges an address byte only when its bits [7:1] equal {DEV_HI, strap_i[1:0]}, with DEV_HI in bits [7:3]. Bit 0 is R/W, where 1 means read. After an address that does not match, the block keeps SDA released and issues no write strobe until the next START.
- R2: In a write, the address byte is followed by the subaddress high byte and then the subaddress low byte. Each data byte after them that is accepted gives exactly one system-cycle pulse on reg_we_o, with reg_addr_o equal to the current subaddress and reg_wdata_o equal to the byte. The byte is then acknowledged. Bits are sent MSB first, and an acknowledge is SDA held low during the ninth SCL pulse.
- R3: After each accepted data byte the subaddress increments by one, so burst data lands in consecutive registers.
- R4: The subaddress high byte is always acknowledged. If the 16-bit subaddress is outside [SUB_LO, SUB_HI], the low byte is not acknowledged and the block goes idle. Data bytes that follow it cause no write.
- R5: A data byte aimed past SUB_HI is not written and is not acknowledged, and the block goes idle.
- R6: After a repeated START and a matching address with R/W=1, the block sends reg_rdata_i for the current subaddress, MSB first. The subaddress advances after each byte that the controller acknowledges.
- R7: During a read, once the subaddress reaches SUB_HI it stays there, so every further byte is the top register.
- R8: When the controller does not acknowledge a read byte, the block releases SDA and does not drive it on later clocks until a new START.
- R9: A START at any point restarts address decode. A STOP at any point returns the block to idle. A partly received byte is discarded in both cases.
- R10: The SDA enable changes only while SCL is low.
- R11: Under reset, sda_oe_o and reg_we_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the pad (asynchronous) |
| strap_i | input | 2 | Low two bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | 16 | Register-bank address (current subaddress) |
| reg_wdata_o | output | 8 | Register-bank write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register-bank read data for reg_addr_o |

## Verification
The hardest state to reach from the ports is a burst that crosses the top of the register window. Some ways in are also hard to reach: a read that starts from a pointer a write left at the top, and a START or STOP that lands in the middle of a byte. The bench uses a small window of eight registers and sweeps the starting subaddress across the whole window. Each write burst and read burst therefore either stays inside the window or runs over its top by one or more bytes. The expected acknowledges and register contents are worked out arithmetically from the start index. Separate sequences cut a byte short after a few bits with a STOP or a repeated START. A following full transaction then shows that nothing partial was written.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int SUB_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK,
        ST_TX,
        ST_TX_DONE,
        ST_MACK,
        ST_MACK_END
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_SUBH,
        PH_SUBL,
        PH_DATA
    } rx_phase_e;

    // Line events seen in the system-clock domain
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    function automatic logic in_window(input logic [SUB_W-1:0] a,
                                       input logic [SUB_W-1:0] lo,
                                       input logic [SUB_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic [SUB_W-1:0] sat_inc(input logic [SUB_W-1:0] a,
                                                 input logic [SUB_W-1:0] hi);
        return (a < hi) ? a + 1'b1 : a;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);

    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [4:0]       DEV_HI = 5'b01110,
    parameter logic [SUB_W-1:0] SUB_LO = 16'h4000,
    parameter logic [SUB_W-1:0] SUB_HI = 16'h40FF
) (
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         evt,
    input  logic [1:0]        strap,
    output logic              sda_oe,
    output logic [SUB_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);

    ctl_state_e        state;
    rx_phase_e         phase;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] subh_q;
    logic [SUB_W-1:0]  ptr_q;
    logic              ack_q, rw_q, past_top, oe_q, we_q;
    logic [BYTE_W-1:0] wdata_q;
    logic [BYTE_W-1:0] byte_in;

    assign byte_in   = {shreg[BYTE_W-2:0], evt.sda};
    assign sda_oe    = oe_q;
    assign reg_addr  = ptr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_DEV;
            bit_cnt  <= '0;
            shreg    <= '0;
            subh_q   <= '0;
            ptr_q    <= SUB_LO;
            ack_q    <= 1'b0;
            rw_q     <= 1'b0;
            past_top <= 1'b0;
            oe_q     <= 1'b0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
        end else begin
            we_q <= 1'b0;
            if (evt.start) begin
                state   <= ST_RX;
                phase   <= PH_DEV;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else if (evt.stop) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: if (evt.scl_rise) begin
                        shreg   <= byte_in;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            state <= ST_ACK_SETUP;
                            unique case (phase)
                                PH_DEV: begin
                                    ack_q <= (byte_in[7:1] == {DEV_HI, strap});
                                    rw_q  <= byte_in[0];
                                end
                                PH_SUBH: begin
                                    ack_q  <= 1'b1;
                                    subh_q <= byte_in;
                                end
                                PH_SUBL: begin
                                    ack_q <= in_window({subh_q, byte_in}, SUB_LO, SUB_HI);
                                    if (in_window({subh_q, byte_in}, SUB_LO, SUB_HI)) begin
                                        ptr_q    <= {subh_q, byte_in};
                                        past_top <= 1'b0;
                                    end
                                end
                                PH_DATA: begin
                                    ack_q   <= ~past_top;
                                    we_q    <= ~past_top;
                                    wdata_q <= byte_in;
                                end
                            endcase
                        end
                    end
                    ST_ACK_SETUP: if (evt.scl_fall) begin
                        if (ack_q) begin
                            oe_q  <= 1'b1;
                            state <= ST_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_ACK: if (evt.scl_fall) begin
                        oe_q    <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_RX;
                        unique case (phase)
                            PH_DEV: begin
                                if (rw_q) begin
                                    shreg <= reg_rdata;
                                    oe_q  <= ~reg_rdata[BYTE_W-1];
                                    state <= ST_TX;
                                end else begin
                                    phase <= PH_SUBH;
                                end
                            end
                            PH_SUBH: phase <= PH_SUBL;
                            PH_SUBL: phase <= PH_DATA;
                            PH_DATA: begin
                                if (ptr_q == SUB_HI) past_top <= 1'b1;
                                else                 ptr_q    <= ptr_q + 1'b1;
                            end
                        endcase
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) state <= ST_TX_DONE;
                        end else if (evt.scl_fall) begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_TX_DONE: if (evt.scl_fall) begin
                        oe_q  <= 1'b0;
                        state <= ST_MACK;
                    end
                    ST_MACK: if (evt.scl_rise) begin
                        if (!evt.sda) begin
                            ptr_q <= sat_inc(ptr_q, SUB_HI);
                            state <= ST_MACK_END;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_MACK_END: if (evt.scl_fall) begin
                        shreg   <= reg_rdata;
                        oe_q    <= ~reg_rdata[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= ST_TX;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the enable moves only in the cycle after a falling SCL edge or a bus condition
    a_r10_oe_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> ($past(evt.scl_fall) || $past(evt.start) || $past(evt.stop)));

    // R2: the write strobe lasts a single system cycle
    a_r2_we_single_cycle: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R7: the register address never leaves the implemented window
    a_r7_addr_in_window: assert property (@(posedge clk) disable iff (rst)
        in_window(reg_addr, SUB_LO, SUB_HI));

    // R9: a STOP releases the data line
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_oe);

    // R5: no strobe once the pointer has run past the top
    a_r5_no_write_past_top: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !$past(past_top));

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [4:0]       DEV_HI      = 5'b01110,
    parameter logic [SUB_W-1:0] SUB_LO      = 16'h4000,
    parameter logic [SUB_W-1:0] SUB_HI      = 16'h40FF,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe_o,
    output logic [SUB_W-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);

    line_evt_t evt;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_target_ctrl #(
        .DEV_HI (DEV_HI),
        .SUB_LO (SUB_LO),
        .SUB_HI (SUB_HI)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .strap     (strap_i),
        .sda_oe    (sda_oe_o),
        .reg_addr  (reg_addr_o),
        .reg_wdata (reg_wdata_o),
        .reg_we    (reg_we_o),
        .reg_rdata (reg_rdata_i)
    );

endmodule

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;

    localparam logic [4:0]  DEV_HI = 5'b01110;
    localparam logic [15:0] LO     = 16'h4000;
    localparam logic [15:0] HI     = 16'h4007;
    localparam int          NREG   = 8;
    localparam int          Q      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b00;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        reg_we;
    logic        sda_line;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regbank_target #(
        .DEV_HI (DEV_HI),
        .SUB_LO (LO),
        .SUB_HI (HI)
    ) i_i2c_regbank_target (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .sda_oe_o    (sda_oe),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_rdata_i (reg_rdata)
    );

    logic [7:0] bank [NREG];
    logic [7:0] expv [NREG];
    int         we_cnt, edge_viol, oe_hits;
    logic       prev_oe;
    logic       watch_oe = 1'b0;
    int         checks = 0;
    int         fails  = 0;

    always_comb reg_rdata = (reg_addr >= LO && reg_addr <= HI) ? bank[reg_addr[2:0]] : 8'hEE;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) bank[i] <= 8'(8'h10 + i);
            we_cnt    <= 0;
            edge_viol <= 0;
            oe_hits   <= 0;
            prev_oe   <= 1'b0;
        end else begin
            if (reg_we) begin
                bank[reg_addr[2:0]] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            prev_oe <= sda_oe;
            if (sda_oe != prev_oe && scl_m) edge_viol <= edge_viol + 1;
            if (watch_oe && sda_oe) oe_hits <= oe_hits + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expd);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(2 * Q);
    endtask

    task automatic clock_bit(input bit b, output bit seen);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(Q);
        seen  = sda_line; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(!give_ack, s);
        sda_m = 1'b1;
    endtask

    task automatic wr_burst(input logic [1:0] dev_lo, input logic [15:0] sub, input int n,
                            input logic [7:0] seed, output bit dack, output bit hack,
                            output bit lack, output int nacked);
        bit a;
        nacked = 0;
        bus_start();
        send_byte({DEV_HI, dev_lo, 1'b0}, dack);
        send_byte(sub[15:8], hack);
        send_byte(sub[7:0], lack);
        for (int i = 0; i < n; i++) begin
            send_byte(8'(seed + i), a);
            if (!a) break;
            nacked++;
        end
        bus_stop();
    endtask

    task automatic cmp_bank(input string tag);
        for (int i = 0; i < NREG; i++) chk(bank[i] == expv[i], tag, bank[i], expv[i]);
    endtask

    initial begin
        bit dack, hack, lack, a, s;
        int got_n, w0;
        logic [7:0] rb;
        logic [15:0] bad [4];

        for (int i = 0; i < NREG; i++) expv[i] = 8'(8'h10 + i);
        hold(5);
        // R11: reset state
        chk(sda_oe == 1'b0, "R11 oe in reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R11 we in reset", reg_we, 0);
        rst = 1'b0;
        hold(4);

        // R1: every strap value against every low address pair
        for (int sv = 0; sv < 4; sv++) begin
            for (int av = 0; av < 4; av++) begin
                int idx;
                idx   = (sv * 4 + av) % NREG;
                strap = 2'(sv);
                w0    = we_cnt;
                wr_burst(2'(av), LO + 16'(idx), 1, 8'(8'hA0 + sv * 4 + av), dack, hack, lack, got_n);
                chk(dack == (sv == av), "R1 address ack", dack, sv == av);
                chk((we_cnt - w0) == ((sv == av) ? 1 : 0), "R1 strobe count", we_cnt - w0, sv == av);
                if (sv == av) expv[idx] = 8'(8'hA0 + sv * 4 + av);
            end
        end
        cmp_bank("R1 bank contents");

        // R2 R3 R5: three-byte bursts from every start index
        strap = 2'b01;
        for (int k = 0; k < NREG; k++) begin
            int nexp;
            nexp = (NREG - k < 3) ? NREG - k : 3;
            w0 = we_cnt;
            wr_burst(2'b01, LO + 16'(k), 3, 8'(8'h30 + k * 8), dack, hack, lack, got_n);
            chk(got_n == nexp, (k + 3 > NREG) ? "R5 acks past top" : "R3 burst acks", got_n, nexp);
            chk((we_cnt - w0) == nexp, "R2 strobes per burst", we_cnt - w0, nexp);
            for (int i = 0; i < nexp; i++) expv[k + i] = 8'(8'h30 + k * 8 + i);
            cmp_bank("R3 burst contents");
        end

        // R4: subaddresses outside the window
        bad[0] = 16'h3FFF; bad[1] = 16'h4008; bad[2] = 16'h0003; bad[3] = 16'h4100;
        foreach (bad[j]) begin
            w0 = we_cnt;
            wr_burst(2'b01, bad[j], 1, 8'h99, dack, hack, lack, got_n);
            chk(hack == 1'b1, "R4 high byte ack", hack, 1);
            chk(lack == 1'b0, "R4 low byte nack", lack, 0);
            chk(got_n == 0 && we_cnt == w0, "R4 no write", we_cnt - w0, 0);
        end
        cmp_bank("R4 bank untouched");

        // R6 R7 R8: four-byte reads from every start index
        for (int k = 0; k < NREG; k++) begin
            bus_start();
            send_byte({DEV_HI, 2'b01, 1'b0}, a);
            send_byte(LO[15:8], a);
            send_byte(8'(LO[7:0] + k), a);
            bus_start();
            send_byte({DEV_HI, 2'b01, 1'b1}, a);
            chk(a == 1'b1, "R6 read address ack", a, 1);
            for (int i = 0; i < 4; i++) begin
                int ix;
                ix = (k + i > NREG - 1) ? NREG - 1 : k + i;
                recv_byte(i < 3, rb);
                chk(rb == expv[ix], (k + i > NREG - 1) ? "R7 saturated read" : "R6 read data", rb, expv[ix]);
            end
            watch_oe = 1'b1;
            for (int i = 0; i < 9; i++) clock_bit(1'b1, s);
            watch_oe = 1'b0;
            chk(oe_hits == 0, "R8 released after nack", oe_hits, 0);
            bus_stop();
        end

        // R9: STOP in the middle of the low subaddress byte
        w0 = we_cnt;
        bus_start();
        send_byte({DEV_HI, 2'b01, 1'b0}, a);
        send_byte(LO[15:8], a);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_stop();
        chk(we_cnt == w0, "R9 stop aborts", we_cnt - w0, 0);
        wr_burst(2'b01, LO + 16'd2, 1, 8'h5A, dack, hack, lack, got_n);
        expv[2] = 8'h5A;
        chk(got_n == 1, "R9 write after stop", got_n, 1);

        // R9: repeated START in the middle of a data byte
        w0 = we_cnt;
        bus_start();
        send_byte({DEV_HI, 2'b01, 1'b0}, a);
        send_byte(LO[15:8], a);
        send_byte(8'(LO[7:0] + 3), a);
        for (int i = 0; i < 3; i++) clock_bit(1'b1, s);
        bus_start();
        send_byte({DEV_HI, 2'b01, 1'b0}, dack);
        send_byte(LO[15:8], a);
        send_byte(8'(LO[7:0] + 4), a);
        send_byte(8'h77, a);
        bus_stop();
        expv[4] = 8'h77;
        chk(dack == 1'b1, "R9 address after restart", dack, 1);
        chk((we_cnt - w0) == 1, "R9 single strobe after restart", we_cnt - w0, 1);
        cmp_bank("R9 bank contents");

        // R10: enable never moved while SCL was high
        chk(edge_viol == 0, "R10 enable timing", edge_viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule